// File: doc/BRIEF.md
# Trace Stream Packet Framer

This block sits on the byte stream that leaves a processor's instruction-trace port and cuts it into packets for a set of per-type payload decoders. It first has to find alignment: until a run of four zero bytes followed by 0x80 has passed by, it stays silent. From then on it treats the first byte of every packet as a header, classifies it by bit masks, and pulses a packet-start strobe with a type code. Every byte also carries an index that gives its position inside the current packet.

The framer does not know how long each packet is. The payload decoder that owns the current packet raises a done strobe when its packet is complete, and the next byte is then read as a header. Alignment detection runs apart from framing and wins over any packet in progress. An idle gap on the port also discards a partial packet, because the bytes on either side of a long pause cannot belong to the same packet. A packet that grows beyond the buffer limit is dropped and reported.

Top module: `trace_pkt_framer`

## Requirements
- R1: After reset, `sync_found`, `pkt_start`, `ovf_err`, `byte_idx` and `pkt_type` are all zero.
- R2: When an accepted 0x80 byte follows at least four consecutive accepted 0x00 bytes, the outputs change in the next cycle. `sync_found` is set and stays set. `pkt_start` pulses with `pkt_type` = 9 and `byte_idx` = 4. This applies whatever packet was being assembled, and the next byte is read as a header.
- R3: While `sync_found` is low, `pkt_start` never pulses.
- R4: A header byte h is classified by the first rule that matches, in this order:
  - h[0]=1 gives 1.
  - h=0x08 gives 2.
  - h=0x70 gives 3.
  - (h&0xF3) in {0x20,0x40,0x60} gives 4.
  - (h&0xDF) in {0x54,0x58,0x5C} gives 5.
  - (h&0xD3)=0x02 gives 6.
  - (h&0xFB)=0x42 gives 7.
  - (h&0x81)=0x80 gives 8.
  - Any other byte gives 0 (unknown).
- R5: When synchronized, a byte that arrives with the buffer empty is a header. One cycle later `pkt_start` pulses with its type and `byte_idx` = 0. Each later byte of the same packet raises `byte_idx` by one and does not pulse `pkt_start`.
- R6: A `pkt_done` strobe empties the buffer. A byte that arrives in the same cycle as `pkt_done`, or after it, is a header.
- R7: A header of type 0 is a complete one-byte packet, so the next byte is a header.
- R8: With the default 16-byte limit, the 17th byte of a packet pulses `ovf_err` for one cycle instead of `pkt_start`, gives `byte_idx` = 0 and empties the buffer.
- R9: With the default configuration, if 32 or more clock cycles without `byte_vld` precede a byte, the partial packet is discarded and that byte is a header. With 31 or fewer such cycles the packet continues.
- R10: `pkt_start` and `ovf_err` are high only in the cycle right after an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Trace byte present this cycle |
| byte_in | input | 8 | Trace byte |
| pkt_done | input | 1 | Payload decoder reports that the current packet is complete |
| pkt_start | output | 1 | First byte of a new packet was accepted |
| pkt_type | output | 4 | Class of the latest packet |
| byte_idx | output | 4 | Position of the latest byte within its packet |
| sync_found | output | 1 | Alignment pattern has been seen |
| ovf_err | output | 1 | Packet exceeded the buffer limit and was dropped |

## Verification
A wrong framing state shows up at the ports with the very next byte. If the buffer is wrongly held empty, a payload byte pulses `pkt_start` with index 0. If it is wrongly held open, a real header appears as a mid-packet index with no start pulse. A stale zero-run count, or a gap timer that is off by one cycle, does not show until the byte that ends the run or the pause. For that reason the bench places bytes exactly at the pattern and idle boundaries and checks the index of the byte right after each one.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    typedef enum logic [3:0] {
        TY_UNKNOWN  = 4'd0,
        TY_BRANCH   = 4'd1,
        TY_ISYNC    = 4'd2,
        TY_ISYNC_CC = 4'd3,
        TY_GRP_A    = 4'd4,
        TY_GRP_B    = 4'd5,
        TY_GRP_C    = 4'd6,
        TY_GRP_D    = 4'd7,
        TY_PHDR     = 4'd8,
        TY_ASYNC    = 4'd9
    } tpf_type_e;

    localparam logic [7:0] SYNC_TAIL = 8'h80;

    // First-match classification of a header byte.
    function automatic tpf_type_e classify(input logic [7:0] h);
        tpf_type_e t;
        logic [7:0] mf3;
        logic [7:0] mdf;
        mf3 = h & 8'hF3;
        mdf = h & 8'hDF;
        if (h[0])                                          t = TY_BRANCH;
        else if (h == 8'h08)                               t = TY_ISYNC;
        else if (h == 8'h70)                               t = TY_ISYNC_CC;
        else if (mf3 == 8'h20 || mf3 == 8'h40 || mf3 == 8'h60) t = TY_GRP_A;
        else if (mdf == 8'h54 || mdf == 8'h58 || mdf == 8'h5C) t = TY_GRP_B;
        else if ((h & 8'hD3) == 8'h02)                     t = TY_GRP_C;
        else if ((h & 8'hFB) == 8'h42)                     t = TY_GRP_D;
        else if ((h & 8'h81) == 8'h80)                     t = TY_PHDR;
        else                                               t = TY_UNKNOWN;
        return t;
    endfunction

endpackage

// File: rtl/tpf_gap_timer.sv
module tpf_gap_timer #(
    parameter int BYTE_CYC  = 2,
    parameter int GAP_BYTES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    output logic gap_flag
);
    localparam int LIMIT = BYTE_CYC * GAP_BYTES;
    localparam int CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (byte_vld)
            cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign gap_flag = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/tpf_sync_window.sv
module tpf_sync_window
    import tpf_pkg::*;
#(
    parameter int SYNC_ZEROS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       sync_hit
);
    localparam int ZW = $clog2(SYNC_ZEROS + 1);

    logic [ZW-1:0] zcnt_d, zcnt_q;

    always_comb begin
        zcnt_d = zcnt_q;
        if (byte_vld) begin
            if (byte_in != 8'h00)
                zcnt_d = '0;
            else if (zcnt_q != ZW'(SYNC_ZEROS))
                zcnt_d = zcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) zcnt_q <= '0;
        else        zcnt_q <= zcnt_d;
    end

    assign sync_hit = byte_vld && (byte_in == SYNC_TAIL) && (zcnt_q == ZW'(SYNC_ZEROS));
endmodule

// File: rtl/tpf_hdr_classify.sv
module tpf_hdr_classify
    import tpf_pkg::*;
(
    input  logic [7:0] hdr,
    output tpf_type_e  hdr_type
);
    always_comb hdr_type = classify(hdr);
endmodule

// File: rtl/trace_pkt_framer.sv
module trace_pkt_framer
    import tpf_pkg::*;
#(
    parameter int MAX_LEN    = 16,
    parameter int SYNC_ZEROS = 4,
    parameter int BYTE_CYC   = 2,
    parameter int GAP_BYTES  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       pkt_done,
    output logic       pkt_start,
    output logic [3:0] pkt_type,
    output logic [3:0] byte_idx,
    output logic       sync_found,
    output logic       ovf_err
);
    localparam int IDX_W = $clog2(MAX_LEN);

    typedef struct packed {
        logic             synced;
        logic             in_pkt;
        logic [IDX_W-1:0] idx;
        logic             start;
        tpf_type_e        ptype;
        logic             ovf;
    } frm_st_t;

    frm_st_t   st_d, st_q;
    logic      gap_flag;
    logic      sync_hit;
    tpf_type_e hdr_type;

    tpf_gap_timer #(.BYTE_CYC(BYTE_CYC), .GAP_BYTES(GAP_BYTES)) u_gap (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .gap_flag(gap_flag)
    );

    tpf_sync_window #(.SYNC_ZEROS(SYNC_ZEROS)) u_sync (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .sync_hit(sync_hit)
    );

    tpf_hdr_classify u_cls (.hdr(byte_in), .hdr_type(hdr_type));

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.ovf   = 1'b0;
        // Completion and idle gap both close the packet before this byte.
        if (pkt_done)              st_d.in_pkt = 1'b0;
        if (byte_vld && gap_flag)  st_d.in_pkt = 1'b0;
        if (byte_vld) begin
            if (sync_hit) begin
                st_d.synced = 1'b1;
                st_d.start  = 1'b1;
                st_d.ptype  = TY_ASYNC;
                st_d.idx    = IDX_W'(SYNC_ZEROS);
                st_d.in_pkt = 1'b0;
            end else if (!st_d.in_pkt) begin
                st_d.idx = '0;
                if (st_q.synced) begin
                    st_d.start  = 1'b1;
                    st_d.ptype  = hdr_type;
                    st_d.in_pkt = (hdr_type != TY_UNKNOWN);
                end
            end else if (st_q.idx == IDX_W'(MAX_LEN - 1)) begin
                st_d.ovf    = 1'b1;
                st_d.in_pkt = 1'b0;
                st_d.idx    = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{synced: 1'b0, in_pkt: 1'b0, idx: '0, start: 1'b0,
                      ptype: TY_UNKNOWN, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pkt_start  = st_q.start;
    assign pkt_type   = st_q.ptype;
    assign byte_idx   = 4'(st_q.idx);
    assign sync_found = st_q.synced;
    assign ovf_err    = st_q.ovf;
endmodule

// File: rtl/trace_pkt_framer_chk.sv
module trace_pkt_framer_chk
    import tpf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic [7:0] byte_in,
    input logic       pkt_start,
    input logic [3:0] pkt_type,
    input logic [3:0] byte_idx,
    input logic       sync_found,
    input logic       ovf_err
);
    // R3
    no_start_unsynced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_found |-> !pkt_start);

    // R2
    sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> sync_found);

    // R2
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_found) |-> (pkt_start && pkt_type == 4'(TY_ASYNC)));

    // R2
    async_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && pkt_type == 4'(TY_ASYNC)) |-> byte_idx == 4'd4);

    // R5
    hdr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && pkt_type != 4'(TY_ASYNC)) |-> byte_idx == 4'd0);

    // R4
    branch_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && pkt_type == 4'(TY_BRANCH)) |-> $past(byte_in[0]));

    // R10
    start_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start || ovf_err) |-> $past(byte_vld));

    // R8
    ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> (!pkt_start && byte_idx == 4'd0));
endmodule

bind trace_pkt_framer trace_pkt_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .pkt_start(pkt_start), .pkt_type(pkt_type), .byte_idx(byte_idx),
    .sync_found(sync_found), .ovf_err(ovf_err)
);

// File: tb/trace_pkt_framer_tb.sv
`timescale 1ns/1ps
module trace_pkt_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       pkt_done = 1'b0;
    logic       pkt_start;
    logic [3:0] pkt_type;
    logic [3:0] byte_idx;
    logic       sync_found;
    logic       ovf_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trace_pkt_framer u_dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .pkt_done(pkt_done), .pkt_start(pkt_start), .pkt_type(pkt_type),
        .byte_idx(byte_idx), .sync_found(sync_found), .ovf_err(ovf_err)
    );

    function automatic int exp_type(input logic [7:0] h);
        int a, b;
        a = int'(h & 8'hF3);
        b = int'(h & 8'hDF);
        if (h[0]) return 1;
        if (h == 8'h08) return 2;
        if (h == 8'h70) return 3;
        if (a == 32 || a == 64 || a == 96) return 4;
        if (b == 84 || b == 88 || b == 92) return 5;
        if ((h & 8'hD3) == 8'h02) return 6;
        if ((h & 8'hFB) == 8'h42) return 7;
        if ((h & 8'h81) == 8'h80) return 8;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One byte, optionally with pkt_done in the same cycle; outputs sampled after.
    task automatic send(input logic [7:0] b, input bit with_done = 1'b0);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        pkt_done = with_done;
        @(negedge clk);
        byte_vld = 1'b0;
        pkt_done = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sync", int'(sync_found), 0);
        check("R1 start", int'(pkt_start), 0);
        check("R1 ovf", int'(ovf_err), 0);
        check("R1 idx", int'(byte_idx), 0);
        check("R1 type", int'(pkt_type), 0);
        rst_n = 1'b1;

        // R3 no start before sync
        send(8'h01); check("R3 start", int'(pkt_start), 0);
        send(8'h08); check("R3 start", int'(pkt_start), 0);
        send(8'h80); check("R3 start", int'(pkt_start), 0);
        check("R3 sync", int'(sync_found), 0);

        // R2 sync acquisition
        for (int i = 0; i < 4; i++) send(8'h00);
        check("R2 sync before tail", int'(sync_found), 0);
        send(8'h80);
        check("R2 sync", int'(sync_found), 1);
        check("R2 start", int'(pkt_start), 1);
        check("R2 type", int'(pkt_type), 9);
        check("R2 idx", int'(byte_idx), 4);
        @(negedge clk);
        check("R10 start clears", int'(pkt_start), 0);

        // R4 / R5 / R6 / R7 header sweep
        for (int h = 0; h < 256; h++) begin
            int e;
            e = exp_type(8'(h));
            send(8'(h));
            check("R4 type", int'(pkt_type), e);
            check("R5 start", int'(pkt_start), 1);
            check("R5 idx", int'(byte_idx), 0);
            if (e != 0) done_pulse();
        end

        // R7 unknown is one byte long
        send(8'h04); check("R7 type", int'(pkt_type), 0);
        send(8'h11); check("R7 next hdr", int'(pkt_start), 1);
        check("R7 next type", int'(pkt_type), 1);

        // R8 overflow at the 17th byte (packet 0x11 still open)
        for (int i = 1; i < 16; i++) begin
            send(8'h33);
            check("R5 idx run", int'(byte_idx), i);
            check("R5 no start", int'(pkt_start), 0);
        end
        send(8'h33);
        check("R8 ovf", int'(ovf_err), 1);
        check("R8 start", int'(pkt_start), 0);
        check("R8 idx", int'(byte_idx), 0);
        @(negedge clk);
        check("R10 ovf clears", int'(ovf_err), 0);
        send(8'h08);
        check("R8 next hdr", int'(pkt_start), 1);
        check("R8 next type", int'(pkt_type), 2);
        done_pulse();

        // R6 done in the same cycle as a byte
        send(8'h01);
        send(8'h11); check("R6 mid", int'(byte_idx), 1);
        send(8'h08, 1'b1);
        check("R6 start", int'(pkt_start), 1);
        check("R6 type", int'(pkt_type), 2);
        check("R6 idx", int'(byte_idx), 0);
        done_pulse();

        // R9 idle gap boundary: 31 idle cycles keep, 32 discard
        send(8'h01);
        idle(30);
        send(8'h33);
        check("R9 short gap idx", int'(byte_idx), 1);
        check("R9 short gap start", int'(pkt_start), 0);
        idle(31);
        send(8'h11);
        check("R9 long gap start", int'(pkt_start), 1);
        check("R9 long gap type", int'(pkt_type), 1);
        check("R9 long gap idx", int'(byte_idx), 0);

        // R2 sync overrides the open packet
        send(8'h05); check("R2 mid idx", int'(byte_idx), 1);
        for (int i = 0; i < 4; i++) send(8'h00);
        check("R2 zeros are payload", int'(byte_idx), 5);
        send(8'h80);
        check("R2 override start", int'(pkt_start), 1);
        check("R2 override type", int'(pkt_type), 9);
        check("R2 override idx", int'(byte_idx), 4);
        send(8'h70);
        check("R2 after sync hdr", int'(pkt_start), 1);
        check("R2 after sync type", int'(pkt_type), 3);
        check("R2 still synced", int'(sync_found), 1);

        finished = 1'b1;
        summary();
    end
endmodule